// File: doc/BRIEF.md
# Program ROM Table Read Unit

This unit performs table-lookup reads of 16-bit words from program ROM for a small 8-bit CPU core. The core issues a command that names a destination data register and picks one of two address sources. A current-page read joins the five upper program counter bits with the 8-bit table pointer. A last-page read forces the upper five address bits to all ones and takes the low eight bits from the table pointer.

Each accepted command occupies the unit for exactly two cycles. In the first cycle the 13-bit address is presented to a synchronous ROM. In the second cycle the fetched word's low byte is handed to the core's register file through a one-cycle write strobe. At the end of that cycle the word's high byte is latched into a dedicated table-high register, where the core can read it later. While the unit is busy, further commands are dropped, so the decoder must wait until busy falls.

The ROM contents are not programmable here. They come from an internal generator that returns a known word for every address. Reset is asserted asynchronously and active-low, and its release is synchronised internally over two clock edges.

Top module: `tblrd_unit`

## Requirements
- R1: While reset is held, busy and wr_en are 0 and tbl_high reads 0x00.
- R2: For a current-page command (cmd_last_page=0), rom_addr equals {pc_hi, tbl_ptr} from the cycle after acceptance until the read completes.
- R3: For a last-page command (cmd_last_page=1), rom_addr equals {5'b11111, tbl_ptr} over the same window.
- R4: A command is accepted on a clock edge where cmd_valid=1 and busy=0. busy is then 1 for exactly the two following cycles.
- R5: A command presented while busy is 1 is dropped: it starts no read and alters neither the address nor the destination of the read in progress.
- R6: wr_en is 1 for exactly one cycle, the second busy cycle. In that cycle wr_addr equals the accepted cmd_dest and wr_data equals the low byte of the fetched word.
- R7: At the end of the second busy cycle, tbl_high takes the high byte of the fetched word.
- R8: tbl_high keeps its value at all other times.
- R9: cmd_dest, tbl_ptr, pc_hi and cmd_last_page are sampled only at the acceptance edge. Later changes do not affect the read.
- R10: The ROM word at address a has low byte a[7:0] XOR 0x3C and high byte {3'b110, a[12:8]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Table read command request |
| cmd_last_page | input | 1 | 1 = read from the fixed last page, 0 = read from the current page |
| cmd_dest | input | 8 | Data register address that receives the low byte |
| tbl_ptr | input | 8 | Table pointer, address bits 7..0 |
| pc_hi | input | 5 | Program counter bits 12..8 |
| busy | output | 1 | Read in progress |
| rom_addr | output | 13 | ROM address of the current read |
| wr_en | output | 1 | Low-byte write strobe to the register file |
| wr_addr | output | 8 | Register file write address |
| wr_data | output | 8 | Low byte of the fetched word |
| tbl_high | output | 8 | Latched high byte of the last completed read |

## Verification
For an acceptance edge E0, busy and rom_addr are due in the cycle after E0. wr_en, wr_addr and wr_data are due in the cycle after E1, the next edge. tbl_high carries the new high byte from the cycle after E2. The bench updates a behavioural phase model on each rising edge with the inputs present at that edge, and compares every output at the following falling edge, so each result is checked in exactly the cycle it is due. Directed checks after a known read and an idle gap confirm the literal high byte and the number of write strobes produced by a held request.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;

  typedef enum logic [1:0] {
    TR_IDLE = 2'd0,
    TR_ADDR = 2'd1,
    TR_DATA = 2'd2
  } tr_state_e;

  // Generator constants for the internal ROM contents
  localparam logic [7:0] ROM_LO_MASK = 8'h3C;
  localparam int unsigned ROM_HI_TAG = 6;

endpackage

// File: rtl/tblrd_seq.sv
module tblrd_seq
  import tblrd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  output logic accept,
  output logic addr_phase,
  output logic data_phase,
  output logic busy
);

  tr_state_e state_q;
  tr_state_e state_d;

  assign accept = cmd_valid && (state_q == TR_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      TR_IDLE: if (accept) state_d = TR_ADDR;
      TR_ADDR: state_d = TR_DATA;
      TR_DATA: state_d = TR_IDLE;
      default: state_d = TR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= TR_IDLE;
    else        state_q <= state_d;
  end

  assign addr_phase = (state_q == TR_ADDR);
  assign data_phase = (state_q == TR_DATA);
  assign busy       = (state_q != TR_IDLE);

endmodule

// File: rtl/tblrd_addr.sv
module tblrd_addr #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned PTR_W  = 8,
  localparam int unsigned PAGE_W = ADDR_W - PTR_W
) (
  input  logic              last_page,
  input  logic [PAGE_W-1:0] pc_hi,
  input  logic [PTR_W-1:0]  ptr,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [PAGE_W-1:0] LAST_PAGE = {PAGE_W{1'b1}};

  logic [PAGE_W-1:0] page;

  always_comb begin
    page = last_page ? LAST_PAGE : pc_hi;
    addr = {page, ptr};
  end

endmodule

// File: rtl/tblrd_rom.sv
module tblrd_rom
  import tblrd_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned PTR_W  = 8,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned PAGE_W = ADDR_W - PTR_W,
  localparam int unsigned BYTE_W = DATA_W / 2,
  localparam int unsigned TAG_W  = BYTE_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] q
);

  localparam logic [TAG_W-1:0] HI_TAG = TAG_W'(ROM_HI_TAG);

  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] q_d;
  logic [DATA_W-1:0] q_q;

  // Contents are generated from the address rather than stored
  always_comb begin
    word[BYTE_W-1:0]      = BYTE_W'(addr[PTR_W-1:0] ^ PTR_W'(ROM_LO_MASK));
    word[DATA_W-1:BYTE_W] = {HI_TAG, addr[ADDR_W-1:PTR_W]};
    q_d = en ? word : q_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q = q_q;

endmodule

// File: rtl/tblrd_result.sv
module tblrd_result #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [BYTE_W-1:0] hi_in,
  output logic [BYTE_W-1:0] hi_out
);

  logic [BYTE_W-1:0] hi_d;
  logic [BYTE_W-1:0] hi_q;

  always_comb hi_d = capture ? hi_in : hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else        hi_q <= hi_d;
  end

  assign hi_out = hi_q;

endmodule

// File: rtl/tblrd_unit.sv
module tblrd_unit #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned PTR_W  = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEST_W = 8,
  localparam int unsigned PAGE_W = ADDR_W - PTR_W,
  localparam int unsigned BYTE_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_last_page,
  input  logic [DEST_W-1:0] cmd_dest,
  input  logic [PTR_W-1:0]  tbl_ptr,
  input  logic [PAGE_W-1:0] pc_hi,
  output logic              busy,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              wr_en,
  output logic [DEST_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] tbl_high
);

  // Reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic accept;
  logic addr_phase;
  logic data_phase;

  tblrd_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cmd_valid  (cmd_valid),
    .accept     (accept),
    .addr_phase (addr_phase),
    .data_phase (data_phase),
    .busy       (busy)
  );

  logic [ADDR_W-1:0] addr_new;

  tblrd_addr #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_addr (
    .last_page (cmd_last_page),
    .pc_hi     (pc_hi),
    .ptr       (tbl_ptr),
    .addr      (addr_new)
  );

  // Command capture with explicit clock enable
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [DEST_W-1:0] dest_d, dest_q;

  always_comb begin
    addr_d = accept ? addr_new : addr_q;
    dest_d = accept ? cmd_dest : dest_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q <= '0;
      dest_q <= '0;
    end else begin
      addr_q <= addr_d;
      dest_q <= dest_d;
    end
  end

  logic [DATA_W-1:0] rom_q;

  tblrd_rom #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .DATA_W(DATA_W)) u_rom (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (addr_phase),
    .addr  (addr_q),
    .q     (rom_q)
  );

  tblrd_result #(.BYTE_W(BYTE_W)) u_result (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .capture (data_phase),
    .hi_in   (rom_q[DATA_W-1:BYTE_W]),
    .hi_out  (tbl_high)
  );

  assign rom_addr = addr_q;
  assign wr_en    = data_phase;
  assign wr_addr  = dest_q;
  assign wr_data  = rom_q[BYTE_W-1:0];

endmodule

// File: rtl/tblrd_unit_chk.sv
module tblrd_unit_chk
  import tblrd_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned PTR_W  = 8,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned PAGE_W = ADDR_W - PTR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_last_page,
  input logic [PTR_W-1:0]  tbl_ptr,
  input logic              busy,
  input logic [ADDR_W-1:0] rom_addr,
  input logic              wr_en,
  input logic [BYTE_W-1:0] wr_data,
  input logic [BYTE_W-1:0] tbl_high
);

  // R4
  busy_two_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);

  // R4
  busy_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |=> !busy);

  // R6
  wr_in_second_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> wr_en);

  // R6
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R6
  wr_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  // R5
  addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rom_addr));

  // R9
  ptr_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> rom_addr[PTR_W-1:0] == $past(tbl_ptr));

  // R3
  last_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && $past(cmd_last_page)) |-> (&rom_addr[ADDR_W-1:PTR_W]));

  // R10
  low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_data == BYTE_W'(rom_addr[PTR_W-1:0] ^ PTR_W'(ROM_LO_MASK)));

  // R7
  high_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> tbl_high[PAGE_W-1:0] == $past(rom_addr[ADDR_W-1:PTR_W]));

  // R8
  high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(tbl_high));

endmodule

bind tblrd_unit tblrd_unit_chk #(
  .ADDR_W (ADDR_W),
  .PTR_W  (PTR_W),
  .BYTE_W (BYTE_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_last_page (cmd_last_page),
  .tbl_ptr       (tbl_ptr),
  .busy          (busy),
  .rom_addr      (rom_addr),
  .wr_en         (wr_en),
  .wr_data       (wr_data),
  .tbl_high      (tbl_high)
);

// File: tb/tblrd_unit_test.sv
module tblrd_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_last_page;
  logic [7:0]  cmd_dest;
  logic [7:0]  tbl_ptr;
  logic [4:0]  pc_hi;
  logic        busy;
  logic [12:0] rom_addr;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [7:0]  tbl_high;

  always #10 clk = ~clk;  // 50 MHz

  tblrd_unit uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_last_page (cmd_last_page),
    .cmd_dest      (cmd_dest),
    .tbl_ptr       (tbl_ptr),
    .pc_hi         (pc_hi),
    .busy          (busy),
    .rom_addr      (rom_addr),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .tbl_high      (tbl_high)
  );

  int  errors = 0;
  int  checks = 0;
  bit  cmp_on = 1'b0;
  bit  done   = 1'b0;
  int  wr_seen = 0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Behavioural reference: phase counter plus captured command
  int          m_phase = 0;
  logic [12:0] m_addr  = '0;
  logic [7:0]  m_dest  = '0;
  logic [7:0]  m_hi    = '0;
  bit          m_last  = 1'b0;

  always @(posedge clk) begin
    if (wr_en === 1'b1) wr_seen++;
    if (!rst_n) begin
      m_phase = 0;
      m_hi    = 8'h00;
    end else begin
      case (m_phase)
        0: if (cmd_valid) begin
             m_phase = 1;
             m_addr  = {(cmd_last_page ? 5'h1F : pc_hi), tbl_ptr};
             m_dest  = cmd_dest;
             m_last  = cmd_last_page;
           end
        1: m_phase = 2;
        default: begin
          m_phase = 0;
          m_hi    = {3'b110, m_addr[12:8]};
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R4 busy", 16'(busy), 16'(m_phase != 0));
      chk("R6 wr_en", 16'(wr_en), 16'(m_phase == 2));
      if (m_phase != 0)
        chk(m_last ? "R3 R5 R9 rom_addr" : "R2 R5 R9 rom_addr", 16'(rom_addr), 16'(m_addr));
      if (m_phase == 2) begin
        chk("R6 wr_addr", 16'(wr_addr), 16'(m_dest));
        chk("R6 R10 wr_data", 16'(wr_data), 16'(m_addr[7:0] ^ 8'h3C));
      end
      chk("R7 R8 tbl_high", 16'(tbl_high), 16'(m_hi));
    end
  end

  // One command; operands scrambled right after acceptance (R9)
  task automatic cmd(input bit last, input logic [4:0] pc, input logic [7:0] ptr,
                     input logic [7:0] dest);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_last_page = last; pc_hi = pc; tbl_ptr = ptr; cmd_dest = dest;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_last_page = ~last; pc_hi = ~pc; tbl_ptr = ~ptr; cmd_dest = ~dest;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_last_page = 1'b0;
    cmd_dest = '0; tbl_ptr = '0; pc_hi = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", 16'(busy), 16'h0);
    chk("R1 wr_en", 16'(wr_en), 16'h0);
    chk("R1 tbl_high", 16'(tbl_high), 16'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1'b1;

    // R2: current page
    cmd(1'b0, 5'h03, 8'h10, 8'h40);
    chk("R2 R7 tbl_high literal", 16'(tbl_high), 16'h00C3);
    // R3: last page
    cmd(1'b1, 5'h02, 8'hAA, 8'h41);
    chk("R3 R7 tbl_high literal", 16'(tbl_high), 16'h00DF);
    cmd(1'b0, 5'h1F, 8'hFF, 8'h7F);
    cmd(1'b0, 5'h00, 8'h00, 8'h30);
    chk("R7 R10 tbl_high page 0", 16'(tbl_high), 16'h00C0);

    for (int i = 0; i < 8; i++)
      cmd(i[0], 5'(i * 5 + 1), 8'(i * 37 + 3), 8'(8'h30 + i));

    // R8: hold across idle
    cmd(1'b0, 5'h0A, 8'h55, 8'h50);
    repeat (12) @(negedge clk);
    chk("R8 tbl_high hold", 16'(tbl_high), 16'h00CA);

    // R5: request held for 9 cycles gives reads at 0, 3, 6 only
    begin
      int w0;
      w0 = wr_seen;
      @(negedge clk);
      cmd_valid = 1'b1;
      for (int k = 0; k < 9; k++) begin
        cmd_last_page = k[1];
        pc_hi   = 5'(k + 7);
        tbl_ptr = 8'(k * 29);
        cmd_dest = 8'(8'h60 + k);
        @(negedge clk);
      end
      cmd_valid = 1'b0;
      repeat (4) @(negedge clk);
      chk("R5 write count under held request", 16'(wr_seen - w0), 16'd3);
    end

    cmp_on = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end

endmodule